// File: doc/BRIEF.md
# Conversion sequencer for an external 10-bit analog-to-digital converter

This controller runs an external successive-approximation converter. It divides the system clock down to a conversion clock and hands that clock to the converter as a one-cycle tick. It pulses a start strobe with the channel number. It then counts a fixed number of conversion-clock ticks and captures the converter's 10-bit output. The host writes one control word. That word holds a start bit, a stop bit, two mode bits, a channel number, a clock-select code and an interrupt-timing bit.

Results land in a bank of four result slots. Each slot carries a fresh-result flag and an overwrite flag. A host read port returns one slot and clears its flags. An interrupt output pulses for one cycle at the points in the sequence that the mode defines. The converter stub, the bus and the interrupt controller sit outside the block.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The conversion clock ticks once every 2, 4 or 8 system cycles for clock-select codes 00, 01 and 10.
- R2: A conversion lasts exactly 86 conversion-clock ticks. The start is sampled at edge T. With divisor D, a lone conversion's result and the fall of `busy` appear after edge T+86·D.
- R3: The mode is the pair {`ctl_repeat`,`ctl_scan`}: 00 runs one channel once, 01 scans once, 10 repeats one channel, and 11 repeats the scan.
- R4: Outside mode 10, a result from channel c goes to slot c mod 4, so channels c and c+4 share a slot.
- R5: In mode 10, successive results go to slots 0, 1, 2, 3 and then wrap to 0, whatever the channel.
- R6: A scan converts channels 0 up to the programmed channel in ascending order. Mode 11 starts again at channel 0 right after the last channel.
- R7: `irq` pulses for one cycle after the single conversion of mode 00. In modes 01 and 11 it pulses after the last channel of each scan.
- R8: In mode 10, `irq` pulses after every conversion when `ctl_itm` is 0, and only after writes to slot 3 (every fourth conversion) when it is 1.
- R9: A stored result sets the slot's fresh flag. The slot's overwrite flag is set when a result replaces one that was still fresh. A read with `rd_en` clears both flags.
- R10: `busy` is 0 after reset and rises with an accepted start. A start written while `busy` is high is ignored: no extra conversion and no change of mode, channel or timing.
- R11: A stop written while busy lets the conversion in progress be stored, then ends the sequence and drops `busy`.
- R12: The clock-select field is taken only on writes while idle, and the reserved code 11 leaves the previous selection in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_start | input | 1 | Start a sequence (taken only when idle) |
| ctl_stop | input | 1 | Request the end of a running sequence |
| ctl_repeat | input | 1 | Mode bit: repeat |
| ctl_scan | input | 1 | Mode bit: scan |
| ctl_itm | input | 1 | Interrupt timing for single-channel repeat |
| ctl_chan | input | 3 | Channel, or last channel of a scan |
| ctl_clksel | input | 2 | Conversion clock divisor select |
| rd_en | input | 1 | Read strobe, clears the slot's flags |
| rd_idx | input | 2 | Result slot to read |
| rd_data | output | 10 | Slot result |
| rd_eoc | output | 1 | Slot fresh-result flag |
| rd_ovr | output | 1 | Slot overwrite flag |
| busy | output | 1 | Sequence running |
| irq | output | 1 | One-cycle interrupt request |
| adc_start | output | 1 | Start strobe to the converter |
| adc_tick | output | 1 | Conversion clock enable to the converter |
| adc_chan | output | 3 | Channel being converted |
| adc_data | input | 10 | Converter output |

## Verification
The bench times each run from the start edge to the fall of `busy`. A wrong divisor, an off-by-one tick count or a lost reserved-code guard shows up as a wrong cycle count. The stub tags every result with its channel and a running conversion number. A slot mapping that ignores the mod-4 sharing, a rotation that fails to wrap, or a scan that restarts anywhere but channel 0 therefore leaves the wrong tag in a slot. Stops are timed to fall inside a specific conversion, so a design that aborts at once or runs one conversion too many misses the expected time and interrupt count. A start written mid-run with a different mode and divisor exposes a design that accepts it.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    // Sequencing mode, encoded as {repeat, scan}
    typedef enum logic [1:0] {
        MODE_ONE_ONCE  = 2'b00,
        MODE_SCAN_ONCE = 2'b01,
        MODE_ONE_LOOP  = 2'b10,
        MODE_SCAN_LOOP = 2'b11
    } seq_mode_e;

    localparam logic [1:0] CLKSEL_RSVD = 2'b11;

    // Terminal count of the prescaler for a clock-select code
    function automatic logic [2:0] div_last(input logic [1:0] sel);
        case (sel)
            2'b00:   div_last = 3'd1;
            2'b01:   div_last = 3'd3;
            default: div_last = 3'd7;
        endcase
    endfunction

endpackage

// File: rtl/adc_seq_clkdiv.sv
module adc_seq_clkdiv
    import adc_seq_pkg::*;
#(
    parameter int DIV_W = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] clksel,
    output logic       tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [DIV_W-1:0] lim;

    assign lim = DIV_W'(div_last(clksel));

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        if (!run) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == lim) begin
            st_d.cnt = '0;
            tick     = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int NCHAN     = 8,
    parameter int NRES      = 4,
    parameter int CONV_CLKS = 86,
    localparam int CH_W     = $clog2(NCHAN),
    localparam int IDX_W    = $clog2(NRES),
    localparam int CNT_W    = $clog2(CONV_CLKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic             ctl_start,
    input  logic             ctl_stop,
    input  logic             ctl_repeat,
    input  logic             ctl_scan,
    input  logic             ctl_itm,
    input  logic [CH_W-1:0]  ctl_chan,
    input  logic [1:0]       ctl_clksel,
    input  logic             tick,
    output logic             busy,
    output logic [1:0]       clksel,
    output logic             conv_start,
    output logic [CH_W-1:0]  conv_chan,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic             irq
);

    typedef struct packed {
        logic             busy;
        seq_mode_e        mode;
        logic [CH_W-1:0]  last_ch;
        logic             itm;
        logic [CH_W-1:0]  chan;
        logic [IDX_W-1:0] rot;
        logic [CNT_W-1:0] cnt;
        logic             stop_pend;
        logic             start_p;
        logic             irq;
        logic [1:0]       clksel;
    } fsm_st_t;

    fsm_st_t st_d, st_q;

    logic is_scan, is_rep, scan_last, seq_end, irq_now, stop_now, conv_done;

    always_comb begin
        st_d       = st_q;
        st_d.start_p = 1'b0;
        st_d.irq   = 1'b0;
        wr_en      = 1'b0;
        is_scan    = st_q.mode[0];
        is_rep     = st_q.mode[1];
        scan_last  = (st_q.chan == st_q.last_ch);
        seq_end    = is_scan ? scan_last : 1'b1;
        stop_now   = st_q.stop_pend || (ctl_wr && ctl_stop);
        conv_done  = tick && (st_q.cnt == CNT_W'(CONV_CLKS - 1));
        wr_idx     = (st_q.mode == MODE_ONE_LOOP) ? st_q.rot : st_q.chan[IDX_W-1:0];

        case (st_q.mode)
            MODE_ONE_ONCE: irq_now = 1'b1;
            MODE_ONE_LOOP: irq_now = !st_q.itm || (st_q.rot == IDX_W'(NRES - 1));
            default:       irq_now = scan_last;
        endcase

        if (!st_q.busy) begin
            if (ctl_wr) begin
                if (ctl_clksel != CLKSEL_RSVD) st_d.clksel = ctl_clksel;
                if (ctl_start) begin
                    st_d.busy      = 1'b1;
                    st_d.mode      = seq_mode_e'({ctl_repeat, ctl_scan});
                    st_d.last_ch   = ctl_chan;
                    st_d.itm       = ctl_itm;
                    st_d.chan      = ctl_scan ? '0 : ctl_chan;
                    st_d.rot       = '0;
                    st_d.cnt       = '0;
                    st_d.stop_pend = 1'b0;
                    st_d.start_p   = 1'b1;
                end
            end
        end else begin
            if (ctl_wr && ctl_stop) st_d.stop_pend = 1'b1;
            if (conv_done) begin
                wr_en      = 1'b1;
                st_d.cnt   = '0;
                st_d.irq   = irq_now;
                if (st_q.mode == MODE_ONE_LOOP) st_d.rot = st_q.rot + 1'b1;
                if ((!is_rep && seq_end) || stop_now) begin
                    st_d.busy      = 1'b0;
                    st_d.stop_pend = 1'b0;
                end else begin
                    if (is_scan) st_d.chan = scan_last ? '0 : st_q.chan + 1'b1;
                    st_d.start_p = 1'b1;
                end
            end else if (tick) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mode <= MODE_ONE_ONCE;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy       = st_q.busy;
    assign clksel     = st_q.clksel;
    assign conv_start = st_q.start_p;
    assign conv_chan  = st_q.chan;
    assign irq        = st_q.irq;

endmodule

// File: rtl/adc_seq_bank.sv
module adc_seq_bank #(
    parameter int NRES   = 4,
    parameter int DATA_W = 10,
    localparam int IDX_W = $clog2(NRES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_eoc,
    output logic              rd_ovr
);

    typedef struct packed {
        logic              eoc;
        logic              ovr;
        logic [DATA_W-1:0] data;
    } slot_t;

    typedef struct packed {
        slot_t [NRES-1:0] slot;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic [NRES-1:0] wr_hit, rd_hit;

    for (genvar g = 0; g < NRES; g++) begin : g_hit
        assign wr_hit[g] = wr_en && (wr_idx == IDX_W'(g));
        assign rd_hit[g] = rd_en && (rd_idx == IDX_W'(g));
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NRES; i++) begin
            if (wr_hit[i]) begin
                st_d.slot[i].data = wr_data;
                st_d.slot[i].ovr  = (st_q.slot[i].eoc || st_q.slot[i].ovr) && !rd_hit[i];
                st_d.slot[i].eoc  = 1'b1;
            end else if (rd_hit[i]) begin
                st_d.slot[i].eoc  = 1'b0;
                st_d.slot[i].ovr  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.slot[rd_idx].data;
    assign rd_eoc  = st_q.slot[rd_idx].eoc;
    assign rd_ovr  = st_q.slot[rd_idx].ovr;

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
    parameter int NCHAN     = 8,
    parameter int NRES      = 4,
    parameter int DATA_W    = 10,
    parameter int CONV_CLKS = 86,
    localparam int CH_W     = $clog2(NCHAN),
    localparam int IDX_W    = $clog2(NRES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic              ctl_start,
    input  logic              ctl_stop,
    input  logic              ctl_repeat,
    input  logic              ctl_scan,
    input  logic              ctl_itm,
    input  logic [CH_W-1:0]   ctl_chan,
    input  logic [1:0]        ctl_clksel,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_eoc,
    output logic              rd_ovr,
    output logic              busy,
    output logic              irq,
    output logic              adc_start,
    output logic              adc_tick,
    output logic [CH_W-1:0]   adc_chan,
    input  logic [DATA_W-1:0] adc_data
);

    logic [1:0]       cur_clksel;
    logic             res_wr;
    logic [IDX_W-1:0] res_idx;

    adc_seq_clkdiv #(.DIV_W(3)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (busy),
        .clksel (cur_clksel),
        .tick   (adc_tick)
    );

    adc_seq_fsm #(
        .NCHAN     (NCHAN),
        .NRES      (NRES),
        .CONV_CLKS (CONV_CLKS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr     (ctl_wr),
        .ctl_start  (ctl_start),
        .ctl_stop   (ctl_stop),
        .ctl_repeat (ctl_repeat),
        .ctl_scan   (ctl_scan),
        .ctl_itm    (ctl_itm),
        .ctl_chan   (ctl_chan),
        .ctl_clksel (ctl_clksel),
        .tick       (adc_tick),
        .busy       (busy),
        .clksel     (cur_clksel),
        .conv_start (adc_start),
        .conv_chan  (adc_chan),
        .wr_en      (res_wr),
        .wr_idx     (res_idx),
        .irq        (irq)
    );

    adc_seq_bank #(
        .NRES   (NRES),
        .DATA_W (DATA_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (res_wr),
        .wr_idx  (res_idx),
        .wr_data (adc_data),
        .rd_en   (rd_en),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .rd_eoc  (rd_eoc),
        .rd_ovr  (rd_ovr)
    );

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
    parameter int CONV_CLKS = 86
) (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       irq,
    input logic       adc_start,
    input logic       adc_tick,
    input logic       res_wr,
    input logic [1:0] cur_clksel
);

    logic [15:0] tick_cnt;
    logic        primed;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt <= '0;
            primed   <= 1'b0;
        end else if (adc_start) begin
            tick_cnt <= '0;
            primed   <= 1'b1;
        end else if (adc_tick) begin
            tick_cnt <= tick_cnt + 1'b1;
        end
    end

    // R1: the divisor is at least two, so ticks never come back to back
    assert_tick_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        adc_tick |=> !adc_tick);

    // R2: between two starts exactly CONV_CLKS ticks elapse
    assert_conv_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_start && primed) |-> (tick_cnt == 16'(CONV_CLKS)));

    // R10: the converter is started only inside an accepted sequence
    assert_start_in_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> busy);

    // R7: an interrupt always follows a stored result
    assert_irq_after_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(res_wr));

    // R12: clock selection holds while a sequence runs
    assert_clksel_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cur_clksel));

endmodule

bind adc_seq_ctrl adc_seq_chk #(.CONV_CLKS(CONV_CLKS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .irq        (irq),
    .adc_start  (adc_start),
    .adc_tick   (adc_tick),
    .res_wr     (res_wr),
    .cur_clksel (cur_clksel)
);

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0, ctl_start = 1'b0, ctl_stop = 1'b0;
    logic       ctl_repeat = 1'b0, ctl_scan = 1'b0, ctl_itm = 1'b0;
    logic [2:0] ctl_chan = '0;
    logic [1:0] ctl_clksel = '0;
    logic       rd_en = 1'b0;
    logic [1:0] rd_idx = '0;
    logic [9:0] rd_data;
    logic       rd_eoc, rd_ovr, busy, irq, adc_start, adc_tick;
    logic [2:0] adc_chan;
    logic [9:0] adc_data = '0;

    always #5 clk = ~clk;

    adc_seq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_start(ctl_start),
        .ctl_stop(ctl_stop), .ctl_repeat(ctl_repeat), .ctl_scan(ctl_scan),
        .ctl_itm(ctl_itm), .ctl_chan(ctl_chan), .ctl_clksel(ctl_clksel),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data), .rd_eoc(rd_eoc),
        .rd_ovr(rd_ovr), .busy(busy), .irq(irq), .adc_start(adc_start),
        .adc_tick(adc_tick), .adc_chan(adc_chan), .adc_data(adc_data)
    );

    // Converter stub: result tagged with channel and running conversion number
    int nstarts = 0;
    always @(posedge clk) begin
        if (adc_start) begin
            nstarts  <= nstarts + 1;
            adc_data <= {adc_chan, 7'(nstarts + 1)};
        end
    end

    int irq_cnt = 0;
    always @(negedge clk) if (rst_n && irq) irq_cnt++;

    int n_chk = 0, n_bad = 0;

    task automatic check_eq(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input bit st, input bit sp, input bit rep, input bit scn,
                          input bit itm, input int ch, input int sel);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_start = st; ctl_stop = sp; ctl_repeat = rep;
        ctl_scan = scn; ctl_itm = itm; ctl_chan = 3'(ch); ctl_clksel = 2'(sel);
        @(posedge clk); #1;
        ctl_wr = 1'b0; ctl_start = 1'b0; ctl_stop = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 100000) begin
            @(posedge clk); #1; n++;
        end
    endtask

    function automatic int tag(input int ch, input int seq);
        return (ch << 7) | (seq & 127);
    endfunction

    task automatic read_slot(input string req, input int idx, input bit e_eoc,
                             input bit e_ovr, input int e_data);
        @(negedge clk);
        rd_idx = 2'(idx); #1;
        check_eq(req, int'(rd_eoc), int'(e_eoc));
        check_eq(req, int'(rd_ovr), int'(e_ovr));
        if (e_eoc) check_eq(req, int'(rd_data), e_data);
        rd_en = 1'b1;
        @(posedge clk); #1;
        rd_en = 1'b0;
        check_eq("R9 read clears flag", int'(rd_eoc), 0);
    endtask

    // {repeat, scan, chan[2:0], clksel[1:0], cycles[15:0]}
    localparam logic [22:0] VECS [6] = '{
        {1'b0, 1'b0, 3'd5, 2'd0, 16'd172},
        {1'b0, 1'b0, 3'd2, 2'd1, 16'd344},
        {1'b0, 1'b1, 3'd3, 2'd0, 16'd688},
        {1'b0, 1'b1, 3'd6, 2'd0, 16'd1204},
        {1'b0, 1'b1, 3'd0, 2'd2, 16'd688},
        {1'b0, 1'b0, 3'd7, 2'd2, 16'd688}
    };

    task automatic finish_up;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R10 watchdog: actual still running expected idle");
        finish_up();
    end

    initial begin
        int n, base, tot;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        check_eq("R10 reset busy", int'(busy), 0);
        check_eq("R7 reset irq", int'(irq), 0);
        check_eq("R10 reset start", int'(adc_start), 0);
        for (int i = 0; i < 4; i++) begin
            rd_idx = 2'(i); #1;
            check_eq("R9 reset eoc", int'(rd_eoc), 0);
            check_eq("R9 reset ovr", int'(rd_ovr), 0);
        end

        // Table of single-pass runs (R1, R2, R3, R4, R6, R7)
        for (int v = 0; v < 6; v++) begin
            int ch, sel, cyc;
            bit scn;
            scn = VECS[v][21]; ch = int'(VECS[v][20:18]);
            sel = int'(VECS[v][17:16]); cyc = int'(VECS[v][15:0]);
            base = nstarts; irq_cnt = 0;
            wr_ctl(1'b1, 1'b0, VECS[v][22], scn, 1'b0, ch, sel);
            wait_idle(n);
            check_eq("R1 R2 run length", n, cyc);
            @(negedge clk); #1;
            check_eq("R7 irq count", irq_cnt, 1);
            for (int i = 0; i < 4; i++) begin
                if (scn) begin
                    bit hi, lo;
                    int cw;
                    lo = (i <= ch); hi = (i + 4 <= ch); cw = hi ? i + 4 : i;
                    read_slot("R4 R6 scan slot", i, lo, hi, tag(cw, base + cw + 1));
                end else begin
                    read_slot("R3 R4 single slot", i, (i == ch % 4), 1'b0, tag(ch, base + 1));
                end
            end
        end

        // Single channel repeat, irq every conversion, stop in 6th (R5, R8, R11)
        base = nstarts; irq_cnt = 0;
        wr_ctl(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 5, 0);
        repeat (900) @(posedge clk);
        wr_ctl(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 0, 0);
        wait_idle(n); tot = 901 + n;
        check_eq("R11 stop after in-flight", tot, 1032);
        @(negedge clk); #1;
        check_eq("R8 irq each conversion", irq_cnt, 6);
        read_slot("R5 rotation", 0, 1'b1, 1'b1, tag(5, base + 5));
        read_slot("R5 rotation", 1, 1'b1, 1'b1, tag(5, base + 6));
        read_slot("R5 rotation", 2, 1'b1, 1'b0, tag(5, base + 3));
        read_slot("R5 rotation", 3, 1'b1, 1'b0, tag(5, base + 4));

        // Single channel repeat, irq every fourth, stop in 9th (R5, R8)
        base = nstarts; irq_cnt = 0;
        wr_ctl(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 3, 0);
        repeat (1400) @(posedge clk);
        wr_ctl(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 0, 0);
        wait_idle(n); tot = 1401 + n;
        check_eq("R11 stop after in-flight", tot, 1548);
        @(negedge clk); #1;
        check_eq("R8 irq every fourth", irq_cnt, 2);
        read_slot("R5 wrap", 0, 1'b1, 1'b1, tag(3, base + 9));
        read_slot("R5 wrap", 1, 1'b1, 1'b1, tag(3, base + 6));
        read_slot("R5 wrap", 2, 1'b1, 1'b1, tag(3, base + 7));
        read_slot("R5 wrap", 3, 1'b1, 1'b1, tag(3, base + 8));

        // Repeated scan to channel 2, stop in 5th conversion (R6, R7, R11)
        base = nstarts; irq_cnt = 0;
        wr_ctl(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2, 0);
        repeat (700) @(posedge clk);
        wr_ctl(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 0, 0);
        wait_idle(n); tot = 701 + n;
        check_eq("R11 scan stop", tot, 860);
        @(negedge clk); #1;
        check_eq("R7 irq per scan", irq_cnt, 1);
        read_slot("R6 restart at 0", 0, 1'b1, 1'b1, tag(0, base + 4));
        read_slot("R6 restart at 0", 1, 1'b1, 1'b1, tag(1, base + 5));
        read_slot("R6 restart at 0", 2, 1'b1, 1'b0, tag(2, base + 3));
        read_slot("R6 restart at 0", 3, 1'b0, 1'b0, 0);

        // Start while busy is ignored (R10)
        base = nstarts; irq_cnt = 0;
        wr_ctl(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1, 1);
        repeat (100) @(posedge clk);
        wr_ctl(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 7, 0);
        wait_idle(n); tot = 101 + n;
        check_eq("R10 busy start ignored", tot, 344);
        check_eq("R10 conversions", nstarts - base, 1);
        @(negedge clk); #1;
        check_eq("R10 irq count", irq_cnt, 1);
        read_slot("R10 slot", 1, 1'b1, 1'b0, tag(1, base + 1));
        read_slot("R10 slot", 3, 1'b0, 1'b0, 0);

        // Reserved select code keeps the previous divisor (R12)
        base = nstarts;
        wr_ctl(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0, 3);
        wait_idle(n);
        check_eq("R12 reserved code ignored", n, 344);
        read_slot("R12 slot", 0, 1'b1, 1'b0, tag(0, base + 1));

        // Idle-only config write changes divisor (R12)
        wr_ctl(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 0);
        check_eq("R12 config write stays idle", int'(busy), 0);
        base = nstarts;
        wr_ctl(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4, 3);
        wait_idle(n);
        check_eq("R12 idle select taken", n, 172);
        read_slot("R4 channel 4 to slot 0", 0, 1'b1, 1'b0, tag(4, base + 1));

        finish_up();
    end

endmodule